// File: doc/BRIEF.md
# Landing Pad Control-Flow Checker

This block enforces forward-edge control-flow integrity for one hart. It watches each retiring instruction. When an indirect jump retires while enforcement is active for the current privilege level, the block records that the next retiring instruction must be a landing pad. If that next instruction is anything else, the block raises a one-cycle software-check fault with a fixed trap value. In every case the expectation is then dropped.

The enable that decides whether enforcement is active comes from one of four configuration bits. The choice depends on the current privilege level and on whether the hart is virtualized. The block also keeps a saved copy of the expectation flag for debug mode. It fills that copy on debug entry and reloads the flag from it on debug return. A debugger can overwrite the saved copy. If the extension is built out, the whole block reduces to constant zeros.

Top module: `lp_cfi_guard`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, elp_o, pelp_o and fault_o are 0.
- R2: A 32-bit instruction counts as a landing pad exactly when its low 12 bits are 0x017, whatever its upper 20 bits hold. An AUIPC with a nonzero destination, such as 0x00000097, is not a landing pad.
- R3: Suppose a retiring instruction is an indirect jump, enforcement is active and elp_o is 0. The block then sets elp_o to 1 in the next cycle, unless R4 applies. The indirect jumps are: JALR, with opcode 0x67 and bits 14:12 equal to 0, where rs1 is bits 19:15; C.JR, which is 0x8002 with rs1 in bits 11:7; and C.JALR, which is 0x9002 with rs1 in bits 11:7. For the two compressed forms rs1 must not be zero, and bits 6:2 must be zero.
- R4: If the source register of that indirect jump is x1, x5 or x7, elp_o stays 0.
- R5: Privilege codes are U=0, S=1 and M=3. Code 2 never enables enforcement. The enable is chosen as follows. In M it is lpe_msec_i. In S it is lpe_h_i when virt_i is 1 and lpe_m_i otherwise. In U it is lpe_s_i when supervisor mode exists and lpe_m_i otherwise. When the chosen enable is 0, no indirect jump arms the flag.
- R6: When elp_o is 1 and a retiring instruction is not a landing pad, fault_o is 1 in that same cycle and tval_o is 2. In the next cycle elp_o is 0. In every other cycle fault_o is 0 and tval_o is 0.
- R7: When elp_o is 1 and the retiring instruction is a landing pad, no fault is raised and elp_o returns to 0.
- R8: A landing pad that retires while elp_o is 0 causes no fault and leaves elp_o at 0.
- R9: If retire_i is 0 and no debug event occurs in a cycle, elp_o keeps its value and fault_o is 0.
- R10: On dbg_enter_i, pelp_o takes the current value of elp_o and elp_o is cleared. In that cycle retire_i is ignored.
- R11: On dbg_ret_i, elp_o is reloaded from pelp_o, provided enforcement is active for ret_priv_i and ret_virt_i under the rule in R5. Otherwise elp_o is left as it was.
- R12: pelp_wr_i loads pelp_wdata_i into pelp_o. If dbg_enter_i is asserted in the same cycle, the debug entry wins.
- R13: When the block is built with LP_EXT=0, elp_o, pelp_o and fault_o are always 0, and writes to the saved flag are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | An instruction retires this cycle |
| insn_i | input | 32 | Retiring instruction; compressed forms use bits 15:0 |
| priv_i | input | 2 | Current privilege level |
| virt_i | input | 1 | Current virtualization state |
| lpe_m_i | input | 1 | Machine environment enable |
| lpe_s_i | input | 1 | Supervisor environment enable |
| lpe_h_i | input | 1 | Hypervisor environment enable |
| lpe_msec_i | input | 1 | Machine security enable, used in M |
| dbg_enter_i | input | 1 | Debug mode entry |
| dbg_ret_i | input | 1 | Return from debug mode |
| ret_priv_i | input | 2 | Privilege level being returned to |
| ret_virt_i | input | 1 | Virtualization state being returned to |
| pelp_wr_i | input | 1 | Debugger write strobe for the saved flag |
| pelp_wdata_i | input | 1 | Debugger write data |
| elp_o | output | 1 | Landing pad expected |
| pelp_o | output | 1 | Saved flag for debug mode |
| fault_o | output | 1 | Missing landing pad fault strobe |
| tval_o | output | XLEN | Trap value, equal to 2 while fault_o is high |

## Verification
The assertions assume that dbg_enter_i and dbg_ret_i are never asserted in the same cycle. They also assume that a debug event cycle carries no retirement that matters, because such a retirement is ignored. The stimulus keeps to these assumptions: it drives a debug event only while retire_i is low, and it never raises both debug strobes together. The assertions further assume that priv_i holds a defined code. The table applies code 2 on purpose, to show that this code never enables enforcement.

// File: rtl/lp_cfi_pkg.sv
package lp_cfi_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_R = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  localparam logic [11:0] LPAD_LOW   = 12'h017;
  localparam logic [6:0]  OPC_JALR   = 7'h67;
  localparam logic [2:0]  CQ2_JR_F3  = 3'b100;

  function automatic logic is_link_reg(input logic [4:0] r);
    return (r == 5'd1) || (r == 5'd5) || (r == 5'd7);
  endfunction
endpackage

// File: rtl/lp_cfi_decode.sv
module lp_cfi_decode
  import lp_cfi_pkg::*;
#(
  parameter bit HAS_COMPRESSED = 1'b1
) (
  input  logic [31:0] insn_i,
  output logic        is_lpad_o,
  output logic        is_ijump_o,
  output logic        link_src_o
);
  logic       wide;
  logic       jalr;
  logic       cjump;
  logic [4:0] rs1;

  assign wide      = (insn_i[1:0] == 2'b11);
  assign jalr      = wide && (insn_i[6:0] == OPC_JALR) && (insn_i[14:12] == 3'b000);
  // landing pad is AUIPC with rd=x0; it must win over plain AUIPC
  assign is_lpad_o = wide && (insn_i[11:0] == LPAD_LOW);

  generate
    if (HAS_COMPRESSED) begin : g_rvc
      assign cjump = (insn_i[1:0] == 2'b10) && (insn_i[15:13] == CQ2_JR_F3) &&
                     (insn_i[6:2] == 5'd0) && (insn_i[11:7] != 5'd0);
    end else begin : g_no_rvc
      assign cjump = 1'b0;
    end
  endgenerate

  assign rs1        = wide ? insn_i[19:15] : insn_i[11:7];
  assign is_ijump_o = jalr || cjump;
  assign link_src_o = is_link_reg(rs1);
endmodule

// File: rtl/lp_cfi_lpe_sel.sv
module lp_cfi_lpe_sel
  import lp_cfi_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b1
) (
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  logic       lpe_m_i,
  input  logic       lpe_s_i,
  input  logic       lpe_h_i,
  input  logic       lpe_msec_i,
  output logic       lpe_o
);
  logic u_lpe;

  generate
    if (HAS_SMODE) begin : g_smode
      assign u_lpe = lpe_s_i;
    end else begin : g_no_smode
      assign u_lpe = lpe_m_i;
    end
  endgenerate

  always_comb begin
    unique case (priv_e'(priv_i))
      PRIV_M:  lpe_o = lpe_msec_i;
      PRIV_S:  lpe_o = virt_i ? lpe_h_i : lpe_m_i;
      PRIV_U:  lpe_o = u_lpe;
      default: lpe_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lp_cfi_state.sv
module lp_cfi_state #(
  parameter bit LP_EXT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic retire_i,
  input  logic is_lpad_i,
  input  logic is_ijump_i,
  input  logic link_src_i,
  input  logic lpe_cur_i,
  input  logic dbg_enter_i,
  input  logic dbg_ret_i,
  input  logic lpe_ret_i,
  input  logic pelp_wr_i,
  input  logic pelp_wdata_i,
  output logic elp_o,
  output logic pelp_o,
  output logic fault_o
);
  generate
    if (LP_EXT) begin : g_ext
      logic elp_q, elp_d;
      logic pelp_q, pelp_d;
      logic ret_live;

      // debug events take the cycle; retirement is ignored then
      assign ret_live = retire_i && !dbg_enter_i && !dbg_ret_i;
      assign fault_o  = ret_live && elp_q && !is_lpad_i;

      always_comb begin
        elp_d  = elp_q;
        pelp_d = pelp_q;
        if (pelp_wr_i) pelp_d = pelp_wdata_i;
        if (dbg_enter_i) begin
          pelp_d = elp_q;
          elp_d  = 1'b0;
        end else if (dbg_ret_i) begin
          if (lpe_ret_i) elp_d = pelp_q;
        end else if (ret_live) begin
          if (elp_q)                        elp_d = 1'b0;
          else if (is_ijump_i && lpe_cur_i) elp_d = !link_src_i;
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          elp_q  <= 1'b0;
          pelp_q <= 1'b0;
        end else begin
          elp_q  <= elp_d;
          pelp_q <= pelp_d;
        end
      end

      assign elp_o  = elp_q;
      assign pelp_o = pelp_q;
    end else begin : g_no_ext
      assign elp_o   = 1'b0;
      assign pelp_o  = 1'b0;
      assign fault_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/lp_cfi_guard.sv
module lp_cfi_guard #(
  parameter int unsigned XLEN           = 32,
  parameter bit          LP_EXT         = 1'b1,
  parameter bit          HAS_SMODE      = 1'b1,
  parameter bit          HAS_COMPRESSED = 1'b1,
  parameter int unsigned FAULT_CODE     = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            retire_i,
  input  logic [31:0]     insn_i,
  input  logic [1:0]      priv_i,
  input  logic            virt_i,
  input  logic            lpe_m_i,
  input  logic            lpe_s_i,
  input  logic            lpe_h_i,
  input  logic            lpe_msec_i,
  input  logic            dbg_enter_i,
  input  logic            dbg_ret_i,
  input  logic [1:0]      ret_priv_i,
  input  logic            ret_virt_i,
  input  logic            pelp_wr_i,
  input  logic            pelp_wdata_i,
  output logic            elp_o,
  output logic            pelp_o,
  output logic            fault_o,
  output logic [XLEN-1:0] tval_o
);
  localparam logic [XLEN-1:0] TVAL_LPAD = XLEN'(FAULT_CODE);

  logic is_lpad, is_ijump, link_src;
  logic lpe_cur, lpe_ret;

  lp_cfi_decode #(.HAS_COMPRESSED(HAS_COMPRESSED)) i_decode (
    .insn_i     (insn_i),
    .is_lpad_o  (is_lpad),
    .is_ijump_o (is_ijump),
    .link_src_o (link_src)
  );

  lp_cfi_lpe_sel #(.HAS_SMODE(HAS_SMODE)) i_lpe_cur (
    .priv_i     (priv_i),
    .virt_i     (virt_i),
    .lpe_m_i    (lpe_m_i),
    .lpe_s_i    (lpe_s_i),
    .lpe_h_i    (lpe_h_i),
    .lpe_msec_i (lpe_msec_i),
    .lpe_o      (lpe_cur)
  );

  lp_cfi_lpe_sel #(.HAS_SMODE(HAS_SMODE)) i_lpe_ret (
    .priv_i     (ret_priv_i),
    .virt_i     (ret_virt_i),
    .lpe_m_i    (lpe_m_i),
    .lpe_s_i    (lpe_s_i),
    .lpe_h_i    (lpe_h_i),
    .lpe_msec_i (lpe_msec_i),
    .lpe_o      (lpe_ret)
  );

  lp_cfi_state #(.LP_EXT(LP_EXT)) i_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .retire_i     (retire_i),
    .is_lpad_i    (is_lpad),
    .is_ijump_i   (is_ijump),
    .link_src_i   (link_src),
    .lpe_cur_i    (lpe_cur),
    .dbg_enter_i  (dbg_enter_i),
    .dbg_ret_i    (dbg_ret_i),
    .lpe_ret_i    (lpe_ret),
    .pelp_wr_i    (pelp_wr_i),
    .pelp_wdata_i (pelp_wdata_i),
    .elp_o        (elp_o),
    .pelp_o       (pelp_o),
    .fault_o      (fault_o)
  );

  assign tval_o = fault_o ? TVAL_LPAD : '0;
endmodule

// File: rtl/lp_cfi_guard_sva.sv
module lp_cfi_guard_sva #(
  parameter int unsigned XLEN       = 32,
  parameter bit          LP_EXT     = 1'b1,
  parameter int unsigned FAULT_CODE = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            retire_i,
  input logic [31:0]     insn_i,
  input logic            dbg_enter_i,
  input logic            dbg_ret_i,
  input logic            elp_o,
  input logic            pelp_o,
  input logic            fault_o,
  input logic [XLEN-1:0] tval_o
);
  AST_FAULT_NEEDS_ELP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> elp_o); // R6
  AST_FAULT_CLEARS_ELP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !elp_o); // R6
  AST_FAULT_TVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (tval_o == XLEN'(FAULT_CODE))); // R6
  AST_QUIET_TVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> (tval_o == '0)); // R6
  AST_LPAD_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && insn_i[11:0] == 12'h017) |-> !fault_o); // R7
  AST_IDLE_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_i |-> !fault_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!retire_i && !dbg_enter_i && !dbg_ret_i) |=> $stable(elp_o)); // R9

  generate
    if (LP_EXT) begin : g_ext_chk
      AST_DBG_ENTER_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_enter_i |=> (!elp_o && pelp_o == $past(elp_o))); // R10
    end else begin : g_noext_chk
      AST_EXT_OFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        retire_i |-> (!elp_o && !pelp_o && !fault_o)); // R13
    end
  endgenerate
endmodule

bind lp_cfi_guard lp_cfi_guard_sva #(
  .XLEN(XLEN), .LP_EXT(LP_EXT), .FAULT_CODE(FAULT_CODE)
) i_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .retire_i(retire_i), .insn_i(insn_i),
  .dbg_enter_i(dbg_enter_i), .dbg_ret_i(dbg_ret_i), .elp_o(elp_o),
  .pelp_o(pelp_o), .fault_o(fault_o), .tval_o(tval_o)
);

// File: tb/test_lp_cfi_guard.sv
`timescale 1ns/1ps
module test_lp_cfi_guard;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        retire = 1'b0;
  logic [31:0] insn = 32'h13;
  logic [1:0]  priv = 2'd3;
  logic        virt = 1'b0;
  logic        lpe_m = 1'b0, lpe_s = 1'b0, lpe_h = 1'b0, lpe_msec = 1'b0;
  logic        dbg_enter = 1'b0, dbg_ret = 1'b0;
  logic [1:0]  ret_priv = 2'd3;
  logic        ret_virt = 1'b0;
  logic        pelp_wr = 1'b0, pelp_wdata = 1'b0;
  logic        elp, pelp, fault;
  logic [31:0] tval;
  logic        elp_n, pelp_n, fault_n;
  logic [31:0] tval_n;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  lp_cfi_guard i_lp_cfi_guard (
    .clk_i(clk), .rst_ni(rst_ni), .retire_i(retire), .insn_i(insn),
    .priv_i(priv), .virt_i(virt), .lpe_m_i(lpe_m), .lpe_s_i(lpe_s),
    .lpe_h_i(lpe_h), .lpe_msec_i(lpe_msec), .dbg_enter_i(dbg_enter),
    .dbg_ret_i(dbg_ret), .ret_priv_i(ret_priv), .ret_virt_i(ret_virt),
    .pelp_wr_i(pelp_wr), .pelp_wdata_i(pelp_wdata), .elp_o(elp),
    .pelp_o(pelp), .fault_o(fault), .tval_o(tval)
  );

  lp_cfi_guard #(.LP_EXT(1'b0)) i_lp_cfi_guard_noext (
    .clk_i(clk), .rst_ni(rst_ni), .retire_i(retire), .insn_i(insn),
    .priv_i(priv), .virt_i(virt), .lpe_m_i(lpe_m), .lpe_s_i(lpe_s),
    .lpe_h_i(lpe_h), .lpe_msec_i(lpe_msec), .dbg_enter_i(dbg_enter),
    .dbg_ret_i(dbg_ret), .ret_priv_i(ret_priv), .ret_virt_i(ret_virt),
    .pelp_wr_i(pelp_wr), .pelp_wdata_i(pelp_wdata), .elp_o(elp_n),
    .pelp_o(pelp_n), .fault_o(fault_n), .tval_o(tval_n)
  );

  // {retire, insn, priv, virt, lpe{msec,h,s,m}, exp_fault, exp_elp_next}
  localparam int NV = 24;
  localparam logic [41:0] VEC [NV] = '{
    {1'b1, 32'h00030067, 2'd3, 1'b0, 4'b1111, 1'b0, 1'b1}, // R3 JALR x6
    {1'b1, 32'h00000017, 2'd3, 1'b0, 4'b1111, 1'b0, 1'b0}, // R7
    {1'b1, 32'h00000017, 2'd3, 1'b0, 4'b1111, 1'b0, 1'b0}, // R8
    {1'b1, 32'h00008067, 2'd3, 1'b0, 4'b1111, 1'b0, 1'b0}, // R4 x1
    {1'b1, 32'h00028067, 2'd3, 1'b0, 4'b1111, 1'b0, 1'b0}, // R4 x5
    {1'b1, 32'h00038067, 2'd3, 1'b0, 4'b1111, 1'b0, 1'b0}, // R4 x7
    {1'b1, 32'h00008502, 2'd3, 1'b0, 4'b1111, 1'b0, 1'b1}, // R3 C.JR x10
    {1'b1, 32'h00000013, 2'd3, 1'b0, 4'b1111, 1'b1, 1'b0}, // R6
    {1'b1, 32'h00009502, 2'd3, 1'b0, 4'b1111, 1'b0, 1'b1}, // R3 C.JALR x10
    {1'b0, 32'h00000013, 2'd3, 1'b0, 4'b1111, 1'b0, 1'b1}, // R9
    {1'b1, 32'h00000097, 2'd3, 1'b0, 4'b1111, 1'b1, 1'b0}, // R2 auipc x1
    {1'b1, 32'h00009282, 2'd3, 1'b0, 4'b1111, 1'b0, 1'b0}, // R4 C.JALR x5
    {1'b1, 32'h00030067, 2'd3, 1'b0, 4'b0111, 1'b0, 1'b0}, // R5 M off
    {1'b1, 32'h00030067, 2'd1, 1'b0, 4'b0001, 1'b0, 1'b1}, // R5 S menv
    {1'b1, 32'h12345017, 2'd1, 1'b0, 4'b0001, 1'b0, 1'b0}, // R2 label lpad
    {1'b1, 32'h00030067, 2'd1, 1'b1, 4'b0001, 1'b0, 1'b0}, // R5 VS h off
    {1'b1, 32'h00008502, 2'd1, 1'b1, 4'b0100, 1'b0, 1'b1}, // R5 VS h on
    {1'b1, 32'h00030067, 2'd1, 1'b1, 4'b0100, 1'b1, 1'b0}, // R6 jump w/o pad
    {1'b1, 32'h00030067, 2'd0, 1'b0, 4'b0010, 1'b0, 1'b1}, // R5 U senv
    {1'b1, 32'h00000017, 2'd0, 1'b0, 4'b0010, 1'b0, 1'b0}, // R7
    {1'b1, 32'h00030067, 2'd0, 1'b0, 4'b0001, 1'b0, 1'b0}, // R5 U menv ignored
    {1'b1, 32'h00031067, 2'd3, 1'b0, 4'b1111, 1'b0, 1'b0}, // R3 funct3!=0
    {1'b1, 32'h00008002, 2'd3, 1'b0, 4'b1111, 1'b0, 1'b0}, // R3 C rs1=0
    {1'b1, 32'h00030067, 2'd2, 1'b0, 4'b1111, 1'b0, 1'b0}  // R5 code 2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    @(negedge clk);
    retire = 1'b0; dbg_enter = 1'b0; dbg_ret = 1'b0; pelp_wr = 1'b0;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 elp in reset", {31'd0, elp}, 32'd0);
    check("R1 pelp in reset", {31'd0, pelp}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    step();
    check("R1 elp after reset", {31'd0, elp}, 32'd0);
    check("R1 fault after reset", {31'd0, fault}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      retire = VEC[i][41]; insn = VEC[i][40:9]; priv = VEC[i][8:7];
      virt = VEC[i][6]; lpe_msec = VEC[i][5]; lpe_h = VEC[i][4];
      lpe_s = VEC[i][3]; lpe_m = VEC[i][2];
      #1;
      check($sformatf("R6 fault vec %0d", i), {31'd0, fault}, {31'd0, VEC[i][1]});
      check($sformatf("R6 tval vec %0d", i), tval, VEC[i][1] ? 32'd2 : 32'd0);
      check($sformatf("R13 noext fault vec %0d", i), {31'd0, fault_n}, 32'd0);
      step();
      check($sformatf("R3 elp vec %0d", i), {31'd0, elp}, {31'd0, VEC[i][0]});
      check($sformatf("R13 noext elp vec %0d", i), {31'd0, elp_n}, 32'd0);
    end

    // debug save/restore
    @(negedge clk);
    retire = 1'b1; insn = 32'h00030067; priv = 2'd3; virt = 1'b0;
    lpe_msec = 1'b1; lpe_h = 1'b0; lpe_s = 1'b0; lpe_m = 1'b0;
    step();
    check("R3 arm before debug", {31'd0, elp}, 32'd1);
    @(negedge clk);
    retire = 1'b0; dbg_enter = 1'b1;
    step();
    check("R10 elp cleared on entry", {31'd0, elp}, 32'd0);
    check("R10 pelp saved", {31'd0, pelp}, 32'd1);
    @(negedge clk);
    dbg_enter = 1'b0; dbg_ret = 1'b1; ret_priv = 2'd3; ret_virt = 1'b0;
    step();
    check("R11 restore enabled", {31'd0, elp}, 32'd1);
    @(negedge clk);
    dbg_ret = 1'b0; retire = 1'b1; insn = 32'h00000017;
    #1;
    check("R7 pad after return", {31'd0, fault}, 32'd0);
    step();
    check("R7 elp cleared", {31'd0, elp}, 32'd0);
    @(negedge clk);
    retire = 1'b0; lpe_msec = 1'b0; dbg_ret = 1'b1;
    step();
    check("R11 restore disabled", {31'd0, elp}, 32'd0);
    check("R11 pelp kept", {31'd0, pelp}, 32'd1);
    @(negedge clk);
    dbg_ret = 1'b1; ret_priv = 2'd1; ret_virt = 1'b1; lpe_h = 1'b1; lpe_m = 1'b0;
    step();
    check("R11 restore VS target", {31'd0, elp}, 32'd1);
    @(negedge clk);
    dbg_ret = 1'b0; dbg_enter = 1'b1;
    step();
    check("R10 second entry", {31'd0, pelp}, 32'd1);
    check("R10 elp zero", {31'd0, elp}, 32'd0);

    // debugger writes
    @(negedge clk);
    dbg_enter = 1'b0; pelp_wr = 1'b1; pelp_wdata = 1'b0;
    step();
    check("R12 write zero", {31'd0, pelp}, 32'd0);
    @(negedge clk);
    pelp_wdata = 1'b1;
    step();
    check("R12 write one", {31'd0, pelp}, 32'd1);
    check("R13 noext write ignored", {31'd0, pelp_n}, 32'd0);
    @(negedge clk);
    pelp_wdata = 1'b1; dbg_enter = 1'b1;
    step();
    check("R12 entry wins", {31'd0, pelp}, 32'd0);
    idle_inputs();

    // reset mid-run
    @(negedge clk);
    retire = 1'b1; insn = 32'h00030067; priv = 2'd3; lpe_msec = 1'b1;
    pelp_wr = 1'b1; pelp_wdata = 1'b1;
    step();
    check("R3 armed before reset", {31'd0, elp}, 32'd1);
    @(negedge clk);
    retire = 1'b0; pelp_wr = 1'b0; rst_ni = 1'b0;
    #1;
    check("R1 async clear elp", {31'd0, elp}, 32'd0);
    check("R1 async clear pelp", {31'd0, pelp}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    step();
    check("R1 elp after release", {31'd0, elp}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule